// File: doc/BRIEF.md
# Receive Sampling Delay Calibration Controller

This controller finds a good sampling delay for a source-synchronous 7:1 receive channel. It drives two tap counts for the clock-line delay pair. The primary tap starts at zero. The secondary tap always trails it by a fixed half-bit offset. After each tap step the controller gathers a window of sample pairs, one bit taken through each delay. If any pair in the window disagrees, that tap is marked as a transition.

The search climbs one tap at a time. It ends at the second transition, or at the top of the tap range. The chosen tap is then copied once into the delay setting of every data lane. A one-cycle load strobe tells the lanes to take it, and a done flag stays high. From then on the taps never change until reset.

The search starts only when the delay elements report ready and the clock generator reports lock. The half-bit offset is a parameter, so the block can be set for any line rate and delay resolution.

Top module: `dlycal_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `master_tap` is 0, `slave_tap` is HALF_TAPS, `cal_done` is 0, `lane_load` is 0 and every lane tap is 0.
- R2: `slave_tap` always equals `master_tap` + HALF_TAPS, clamped at 2^TAP_W-1 (511 by default).
- R3: The search does not start while `dly_ready` or `clk_locked` is low: `master_tap` stays 0 and `cal_done` stays 0.
- R4: After both enables are high, the search begins on the next clock edge. Each tap is held for PAIRS (16) sampled cycles, and `master_tap` then goes up by exactly one. A tap is a transition if `smp_master` and `smp_slave` differ in any of its samples.
- R5: When a second transition is found, the final tap is floor((first + second) / 2).
- R6: If the top tap is reached after exactly one transition, the final tap is that transition's tap + HALF_TAPS, clamped at 511.
- R7: If the top tap is reached with no transition, the final tap is HALF_TAPS.
- R8: The tap never rises above 511; the search ends when the window at tap 511 completes.
- R9: When the search ends, `cal_done` rises and `master_tap` holds the final tap. One cycle later `lane_load` is high for exactly one cycle. At that point every lane field of `lane_taps` (lane i at bits [i*TAP_W +: TAP_W]) holds the final tap.
- R10: Once `cal_done` is high, no sample input changes `master_tap`, `slave_tap` or `lane_taps`, and `lane_load` stays low.
- R11: Reset during a search returns the controller to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_ready | input | 1 | Delay elements report ready |
| clk_locked | input | 1 | Clock generator reports lock |
| smp_master | input | 1 | Bit sampled through the primary delay |
| smp_slave | input | 1 | Bit sampled through the half-bit-offset delay |
| master_tap | output | TAP_W | Primary delay tap count |
| slave_tap | output | TAP_W | Secondary delay tap count |
| lane_taps | output | LANES*TAP_W | Tap value for each data lane |
| lane_load | output | 1 | One-cycle strobe to load the lane taps |
| cal_done | output | 1 | Calibration finished |

## Verification
The search is started on a clock edge, and the first tap step shows up on the 17th falling edge after that. The bench samples exactly there. For the rest of the search, the sample inputs are driven on falling edges by a model of the delay line that reacts to the current `master_tap`. This makes the final tap independent of the exact cycle count. Once `cal_done` is seen, the bench expects the final tap on `master_tap` at that same falling edge. It expects `lane_load` and the lane taps on the next falling edge, and `lane_load` low again on the one after. The frozen state and the reset state are checked on the falling edge after the stimulus that could disturb them.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_SCAN = 2'd1,
    CAL_DONE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/dlycal_window.sv
// Collects PAIRS sample pairs per tap and reports whether any disagreed.
module dlycal_window #(
  parameter int PAIRS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic m_bit,
  input  logic s_bit,
  output logic win_end,
  output logic step_diff
);
  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_comb begin
    win_end   = en && (cnt_q == CW'(PAIRS - 1));
    step_diff = seen_q | (m_bit ^ s_bit);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (win_end) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= step_diff;
    end
  end
endmodule

// File: rtl/dlycal_fanout.sv
// Registers the chosen tap into every lane and issues the load strobe.
module dlycal_fanout #(
  parameter int LANES = 5,
  parameter int TAP_W = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [TAP_W-1:0]       tap_in,
  output logic [LANES*TAP_W-1:0] lane_taps,
  output logic                   lane_load
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        lane_taps[g*TAP_W +: TAP_W] <= '0;
      else if (load)
        lane_taps[g*TAP_W +: TAP_W] <= tap_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lane_load <= 1'b0;
    else     lane_load <= load;
  end

  // R9: the lane strobe never lasts more than one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    lane_load |=> !lane_load);
endmodule

// File: rtl/dlycal_ctrl.sv
module dlycal_ctrl #(
  parameter int TAP_W     = 9,
  parameter int HALF_TAPS = 40,
  parameter int PAIRS     = 16,
  parameter int LANES     = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dly_ready,
  input  logic                   clk_locked,
  input  logic                   smp_master,
  input  logic                   smp_slave,
  output logic [TAP_W-1:0]       master_tap,
  output logic [TAP_W-1:0]       slave_tap,
  output logic [LANES*TAP_W-1:0] lane_taps,
  output logic                   lane_load,
  output logic                   cal_done
);
  import dlycal_pkg::*;

  localparam logic [TAP_W-1:0] TOP_TAP = '1;
  localparam logic [TAP_W-1:0] HALF    = TAP_W'(HALF_TAPS);

  function automatic logic [TAP_W-1:0] sat_add(input logic [TAP_W-1:0] a,
                                               input logic [TAP_W-1:0] b);
    logic [TAP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TAP_W] ? TOP_TAP : s[TAP_W-1:0];
  endfunction

  cal_state_e       st_q, st_n;
  logic [TAP_W-1:0] master_q, master_n, first_q, first_n, fin_val;
  logic             have1_q, have1_n, fin, bcast_q;
  logic             win_end, step_diff;

  dlycal_window #(.PAIRS(PAIRS)) u_window (
    .clk       (clk),
    .rst       (rst),
    .en        (st_q == CAL_SCAN),
    .m_bit     (smp_master),
    .s_bit     (smp_slave),
    .win_end   (win_end),
    .step_diff (step_diff)
  );

  always_comb begin
    st_n     = st_q;
    master_n = master_q;
    first_n  = first_q;
    have1_n  = have1_q;
    fin      = 1'b0;
    fin_val  = '0;
    case (st_q)
      CAL_IDLE: if (dly_ready && clk_locked) st_n = CAL_SCAN;
      CAL_SCAN: if (win_end) begin
        if (step_diff && have1_q) begin
          fin     = 1'b1;
          fin_val = first_q + ((master_q - first_q) >> 1);
        end else begin
          if (step_diff) begin
            first_n = master_q;
            have1_n = 1'b1;
          end
          if (master_q == TOP_TAP) begin
            fin = 1'b1;
            if (step_diff)    fin_val = sat_add(master_q, HALF);
            else if (have1_q) fin_val = sat_add(first_q, HALF);
            else              fin_val = HALF;
          end else begin
            master_n = master_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (fin) begin
      st_n     = CAL_DONE;
      master_n = fin_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= CAL_IDLE;
      master_q  <= '0;
      slave_tap <= HALF;
      first_q   <= '0;
      have1_q   <= 1'b0;
      cal_done  <= 1'b0;
      bcast_q   <= 1'b0;
    end else begin
      st_q      <= st_n;
      master_q  <= master_n;
      slave_tap <= sat_add(master_n, HALF);
      first_q   <= first_n;
      have1_q   <= have1_n;
      cal_done  <= cal_done | fin;
      bcast_q   <= fin;
    end
  end

  assign master_tap = master_q;

  dlycal_fanout #(.LANES(LANES), .TAP_W(TAP_W)) u_fanout (
    .clk       (clk),
    .rst       (rst),
    .load      (bcast_q),
    .tap_in    (master_q),
    .lane_taps (lane_taps),
    .lane_load (lane_load)
  );

  // R2: the secondary tap keeps its half-bit offset
  a_r2_slave_offset: assert property (@(posedge clk) disable iff (rst)
    slave_tap == sat_add(master_tap, HALF));
  // R3: no start without both enables
  a_r3_wait_enable: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAL_IDLE && !(dly_ready && clk_locked)) |=> (st_q == CAL_IDLE));
  // R4: the tap moves only at the end of a window
  a_r4_hold_in_window: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAL_SCAN && !win_end) |=> $stable(master_tap));
  // R4: a step without finishing is exactly one tap
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAL_SCAN && win_end && !fin) |=>
      (master_tap == TAP_W'($past(master_tap) + 1'b1)));
  // R9: the lane load follows completion by one cycle
  a_r9_load_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done) |=> lane_load);
  // R10: nothing moves after completion
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> (cal_done && $stable(master_tap) && $stable(slave_tap)));
endmodule

// File: tb/test_dlycal_ctrl.sv
`timescale 1ns/1ps
module test_dlycal_ctrl;
  localparam int TAP_W = 9;
  localparam int HALF  = 40;
  localparam int LANES = 5;
  localparam int TOPV  = 511;
  localparam int NONE  = 9999;

  logic clk = 1'b0, rst = 1'b1, rdy = 1'b0, lock = 1'b0, sm = 1'b0, ss = 1'b0;
  logic [TAP_W-1:0]       master_tap, slave_tap;
  logic [LANES*TAP_W-1:0] lane_taps;
  logic                   lane_load, cal_done;

  int checks = 0, errors = 0;
  int e1 = NONE, e2 = NONE, nc = 0;
  bit noisy = 1'b0;
  logic [TAP_W-1:0] prev_tap = '0;

  always #2.5 clk = ~clk;

  dlycal_ctrl #(.TAP_W(TAP_W), .HALF_TAPS(HALF), .PAIRS(16), .LANES(LANES)) i_dlycal_ctrl (
    .clk(clk), .rst(rst), .dly_ready(rdy), .clk_locked(lock),
    .smp_master(sm), .smp_slave(ss),
    .master_tap(master_tap), .slave_tap(slave_tap),
    .lane_taps(lane_taps), .lane_load(lane_load), .cal_done(cal_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Delay-line model: disagreement only at edge taps, at least once per window
  task automatic tick();
    bit hit, dis;
    @(negedge clk);
    if (master_tap != prev_tap) nc = 0; else nc++;
    prev_tap = master_tap;
    hit = (int'(master_tap) == e1) || (int'(master_tap) == e2);
    if (noisy) dis = 1'($urandom % 2);
    else       dis = hit && (($urandom % 4 == 0) || nc == 3);
    sm = 1'($urandom % 2);
    ss = sm ^ dis;
  endtask

  function automatic int sat(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  function automatic int expect_tap(input int a, input int b);
    if (a <= TOPV && b <= TOPV) return (a + b) / 2;
    if (a <= TOPV) return sat(a + HALF);
    return HALF;
  endfunction

  task automatic do_reset();
    rst = 1'b1; rdy = 1'b0; lock = 1'b0; noisy = 1'b0; e1 = NONE; e2 = NONE;
    repeat (3) tick();
    rst = 1'b0; nc = 0;
  endtask

  task automatic run_case(input int a, input int b, input string req);
    int n, exp;
    do_reset();
    e1 = a; e2 = b; rdy = 1'b1; lock = 1'b1;
    n = 0;
    while (!cal_done && n < 20000) begin tick(); n++; end
    exp = expect_tap(a, b);
    chk(cal_done == 1'b1, "R9 done", int'(cal_done), 1);
    chk(int'(master_tap) == exp, req, int'(master_tap), exp);
    chk(int'(slave_tap) == sat(exp + HALF), "R2 offset", int'(slave_tap), sat(exp + HALF));
    chk(lane_load == 1'b0, "R9 strobe early", int'(lane_load), 0);
    tick();
    chk(lane_load == 1'b1, "R9 strobe", int'(lane_load), 1);
    for (int i = 0; i < LANES; i++)
      chk(int'(lane_taps[i*TAP_W +: TAP_W]) == exp, "R9 lane tap",
          int'(lane_taps[i*TAP_W +: TAP_W]), exp);
    tick();
    chk(lane_load == 1'b0, "R9 strobe width", int'(lane_load), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit moved;
    int a, b;
    logic [LANES*TAP_W-1:0] lt;
    logic [TAP_W-1:0] mt;
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk(master_tap == '0, "R1 master", int'(master_tap), 0);
    chk(int'(slave_tap) == HALF, "R1 slave", int'(slave_tap), HALF);
    chk(cal_done == 1'b0, "R1 done", int'(cal_done), 0);
    chk(lane_load == 1'b0, "R1 load", int'(lane_load), 0);
    chk(lane_taps == '0, "R1 lanes", int'(lane_taps != '0), 0);

    // R3 gating
    rdy = 1'b1; lock = 1'b0;
    repeat (40) tick();
    chk(master_tap == '0 && !cal_done, "R3 lock low", int'(master_tap), 0);
    rdy = 1'b0; lock = 1'b1;
    repeat (40) tick();
    chk(master_tap == '0 && !cal_done, "R3 ready low", int'(master_tap), 0);

    // R4 step timing: start edge, then 16 sampled cycles per tap
    rdy = 1'b1;
    repeat (16) tick();
    chk(master_tap == '0, "R4 hold", int'(master_tap), 0);
    tick();
    chk(int'(master_tap) == 1, "R4 step", int'(master_tap), 1);
    repeat (16) tick();
    chk(int'(master_tap) == 2, "R4 second step", int'(master_tap), 2);
    chk(int'(slave_tap) == 2 + HALF, "R2 during search", int'(slave_tap), 2 + HALF);

    // R11 reset mid-search
    while (master_tap < 9'd100) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0; rdy = 1'b0; lock = 1'b0;
    tick();
    chk(master_tap == '0, "R11 master", int'(master_tap), 0);
    chk(int'(slave_tap) == HALF && !cal_done, "R11 slave", int'(slave_tap), HALF);

    // Directed corners
    run_case(10, 50, "R5 two edges");
    run_case(1, 2, "R5 adjacent edges");
    run_case(510, 511, "R5 top edges");
    run_case(200, NONE, "R6 one edge");
    run_case(480, NONE, "R8 one edge clamp");
    run_case(511, NONE, "R8 edge at top");
    run_case(NONE, NONE, "R7 no edge");

    // R10 frozen after completion
    noisy = 1'b1; rdy = 1'b1; lock = 1'b1;
    mt = master_tap; lt = lane_taps; moved = 1'b0;
    repeat (200) begin
      tick();
      if (master_tap != mt || lane_taps != lt || lane_load || !cal_done) moved = 1'b1;
    end
    chk(!moved, "R10 frozen", int'(moved), 0);
    noisy = 1'b0;

    // Random two-edge searches
    for (int t = 0; t < 8; t++) begin
      a = 1 + int'($urandom % 150);
      b = a + 1 + int'($urandom % 150);
      run_case(a, b, "R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule